// File: doc/BRIEF.md
# Fractal Transform Feature Engine

This block turns one heartbeat window into a feature vector. The window holds 50 signed 8-bit ECG samples centred on a detected R peak. The 25 samples before the peak form segment 1 and the 25 samples after it form segment 2. Each accepted sample produces one signed 16-bit feature in Q4.12:

feature = c·n' + d·x + f + g·sin(n'/1.6)

Here x is the sample value, and n' is a per-position constant taken from a table. The four map weights (c, d, f, g) are constants that change with the segment.

The sine is a ten-term odd power series. It is evaluated with Horner's rule in u², and a single shared multiplier is stepped over fourteen cycles per sample. Samples enter on a valid/ready stream. Ready stays low while a sample is being processed. Features leave on a one-cycle valid strobe, and a last flag marks the end of the window. A start-of-window input resets the position count.

Top module: `fte_feature_engine`

## Requirements
- R1: After reset, ready_o is 1 and feat_valid_o and feat_last_o are 0. The first sample accepted after reset takes window position 0, even when first_i is low.
- R2: For positions 0..24, the feature equals round(4096·(c·n' + d·x + f + g·sin(n'/1.6))) within 8 LSB. In this formula:
  - x is sample_i read as two's complement with 4 fraction bits (x = sample/16).
  - n' = (k+1)/25, where k is the position.
  - The weights are c=0.8811360429, d=0.8485988992, f=0.3445652340, g=0.3857726869.
- R3: For positions 25..49, the same formula applies with k = position−25. The weights are c=−0.6759430538, d=0.9296483879, f=−0.2087852761, g=0.5826642888.
- R4: Each accepted sample (valid_i and ready_o high at a rising edge) yields exactly one feature. feat_valid_o is high for one cycle, following the 14th rising edge after the accepting edge. ready_o is low from the accepting edge until that edge.
- R5: feat_last_o is high together with the feature of position 49 and with no other feature. The sample after position 49 takes position 0.
- R6: A sample accepted with first_i high takes position 0, and the next sample takes position 1.
- R7: A result outside the Q4.12 range is clamped to 32767 or −32768. It does not wrap.
- R8: While ready_o is low, valid_i, first_i and sample_i have no effect on any feature or on the position count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample offered |
| first_i | input | 1 | Offered sample opens a new window |
| sample_i | input | 8 | Signed sample, 4 fraction bits |
| ready_o | output | 1 | Engine idle, sample can be taken |
| feat_o | output | 16 | Signed Q4.12 feature |
| feat_valid_o | output | 1 | One-cycle strobe for feat_o |
| feat_last_o | output | 1 | Feature belongs to the final window position |

## Verification
Clamping is the hardest behaviour to reach from the ports. It occurs only near the end of segment 1, where a large c·n' adds to a full-scale positive sample. The stimulus therefore opens a window with first_i and walks 25 samples of +127 up to position 24. A second hard case is a sample offered while the engine is busy. To cover it, valid_i and first_i are held high with junk data during the compute phase, and the bench then shows that the next real sample keeps the expected position.

// File: rtl/fte_pkg.sv
package fte_pkg;
  localparam int  QF = 12;   // fraction bits of the internal format
  localparam real FD = 1.6;  // fractal dimension

  typedef enum logic {ST_IDLE, ST_CALC} fte_state_e;

  // seg 0 = before peak; sel 0..3 = c, d, f, g
  function automatic int map_par(input int seg, input int sel);
    real v;
    case ({seg[0], sel[1:0]})
      3'b000: v = 0.8811360429;
      3'b001: v = 0.8485988992;
      3'b010: v = 0.3445652340;
      3'b011: v = 0.3857726869;
      3'b100: v = -0.6759430538;
      3'b101: v = 0.9296483879;
      3'b110: v = -0.2087852761;
      default: v = 0.5826642888;
    endcase
    return int'(v * real'(1 << QF));
  endfunction

  // (-1)^r / (2r+1)!
  function automatic int z_coef(input int r);
    real v = 1.0;
    for (int i = 1; i <= 2*r+1; i++) v = v / real'(i);
    if (r % 2 == 1) v = -v;
    return int'(v * real'(1 << QF));
  endfunction

  function automatic int n_coef(input int k, input int seg_len);
    return int'(real'(k+1) / real'(seg_len) * real'(1 << QF));
  endfunction

  function automatic int u_coef(input int k, input int seg_len);
    return int'(real'(k+1) / real'(seg_len) / FD * real'(1 << QF));
  endfunction
endpackage

// File: rtl/fte_sat.sv
module fte_sat #(
  parameter int IW = 32,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] d_i,
  output logic signed [OW-1:0] q_o
);
  logic [IW-OW:0] hi;
  assign hi = d_i[IW-1:OW-1];

  always_comb begin
    if (hi == '0 || hi == '1) q_o = d_i[OW-1:0];
    else if (d_i[IW-1])       q_o = {1'b1, {(OW-1){1'b0}}};
    else                      q_o = {1'b0, {(OW-1){1'b1}}};
  end
endmodule

// File: rtl/fte_qmul.sv
module fte_qmul #(
  parameter int DW = 16,
  parameter int QF = 12
) (
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] p_o
);
  logic signed [2*DW-1:0] full, sh;
  assign full = (2*DW)'(a_i) * (2*DW)'(b_i);
  assign sh   = full >>> QF;  // floor rounding

  fte_sat #(.IW(2*DW), .OW(DW)) u_sat (.d_i(sh), .q_o(p_o));
endmodule

// File: rtl/fte_coef_rom.sv
module fte_coef_rom
  import fte_pkg::*;
#(
  parameter int SEG_LEN = 25,
  parameter int TERMS   = 10,
  parameter int DW      = 16,
  parameter int KW      = $clog2(SEG_LEN),
  parameter int TW      = $clog2(TERMS)
) (
  input  logic [KW-1:0]        k_i,
  input  logic                 seg_i,
  input  logic [TW-1:0]        z_idx_i,
  output logic signed [DW-1:0] c_o,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] f_o,
  output logic signed [DW-1:0] g_o,
  output logic signed [DW-1:0] n_o,
  output logic signed [DW-1:0] u_o,
  output logic signed [DW-1:0] z_o,
  output logic signed [DW-1:0] z_top_o
);
  logic signed [DW-1:0] n_tab [SEG_LEN];
  logic signed [DW-1:0] u_tab [SEG_LEN];
  logic signed [DW-1:0] z_tab [TERMS];

  for (genvar k = 0; k < SEG_LEN; k++) begin : g_pos
    assign n_tab[k] = DW'(n_coef(k, SEG_LEN));
    assign u_tab[k] = DW'(u_coef(k, SEG_LEN));
  end
  for (genvar r = 0; r < TERMS; r++) begin : g_term
    assign z_tab[r] = DW'(z_coef(r));
  end

  assign n_o     = n_tab[k_i];
  assign u_o     = u_tab[k_i];
  assign z_o     = z_tab[z_idx_i];
  assign z_top_o = z_tab[TERMS-1];

  assign c_o = seg_i ? DW'(map_par(1, 0)) : DW'(map_par(0, 0));
  assign d_o = seg_i ? DW'(map_par(1, 1)) : DW'(map_par(0, 1));
  assign f_o = seg_i ? DW'(map_par(1, 2)) : DW'(map_par(0, 2));
  assign g_o = seg_i ? DW'(map_par(1, 3)) : DW'(map_par(0, 3));
endmodule

// File: rtl/fte_feature_engine.sv
module fte_feature_engine
  import fte_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int SAMPLE_FRAC = 4,
  parameter int DW          = 16,
  parameter int SEG_LEN     = 25,
  parameter int TERMS       = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                first_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                ready_o,
  output logic [DW-1:0]       feat_o,
  output logic                feat_valid_o,
  output logic                feat_last_o
);
  localparam int WIN   = 2 * SEG_LEN;
  localparam int NSTEP = TERMS + 4;
  localparam int PW    = $clog2(WIN);
  localparam int KW    = $clog2(SEG_LEN);
  localparam int TW    = $clog2(TERMS);
  localparam int SW    = $clog2(NSTEP);
  localparam int AW    = DW + 4;
  localparam int XSH   = QF - SAMPLE_FRAC;

  fte_state_e           state_q;
  logic [SW-1:0]        step_q;
  logic [PW-1:0]        pos_q, cnt_q, pos_in;
  logic                 last_q, accept, seg;
  logic [KW-1:0]        k;
  logic [TW-1:0]        z_idx;
  logic signed [DW-1:0] x_q, s_q, acc_q;
  logic signed [AW-1:0] sum_q, fin;
  logic signed [DW-1:0] c_c, d_c, f_c, g_c, n_c, u_c, z_c, z_top;
  logic signed [DW-1:0] op_a, op_b, prod, fin_sat;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = valid_i && ready_o;
  assign pos_in  = first_i ? '0 : cnt_q;
  assign seg     = (pos_q >= PW'(SEG_LEN));
  assign k       = seg ? KW'(pos_q - PW'(SEG_LEN)) : KW'(pos_q);

  always_comb begin
    z_idx = '0;
    if (step_q != '0 && int'(step_q) < TERMS) z_idx = TW'(TERMS - 1 - int'(step_q));
  end

  fte_coef_rom #(.SEG_LEN(SEG_LEN), .TERMS(TERMS), .DW(DW), .KW(KW), .TW(TW)) u_rom (
    .k_i(k), .seg_i(seg), .z_idx_i(z_idx),
    .c_o(c_c), .d_o(d_c), .f_o(f_c), .g_o(g_c),
    .n_o(n_c), .u_o(u_c), .z_o(z_c), .z_top_o(z_top)
  );

  // step 0: u^2; 1..TERMS-1: Horner; TERMS: *u; then g*sin, c*n', d*x
  always_comb begin
    if (step_q == '0)                     begin op_a = u_c;   op_b = u_c;   end
    else if (int'(step_q) < TERMS)        begin op_a = acc_q; op_b = s_q;   end
    else if (int'(step_q) == TERMS)       begin op_a = acc_q; op_b = u_c;   end
    else if (int'(step_q) == TERMS + 1)   begin op_a = g_c;   op_b = acc_q; end
    else if (int'(step_q) == TERMS + 2)   begin op_a = c_c;   op_b = n_c;   end
    else                                  begin op_a = d_c;   op_b = x_q;   end
  end

  fte_qmul #(.DW(DW), .QF(QF)) u_mul (.a_i(op_a), .b_i(op_b), .p_o(prod));

  assign fin = sum_q + AW'(prod);
  fte_sat #(.IW(AW), .OW(DW)) u_sat (.d_i(fin), .q_o(fin_sat));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      pos_q        <= '0;
      cnt_q        <= '0;
      last_q       <= 1'b0;
      x_q          <= '0;
      s_q          <= '0;
      acc_q        <= '0;
      sum_q        <= '0;
      feat_o       <= '0;
      feat_valid_o <= 1'b0;
      feat_last_o  <= 1'b0;
    end else begin
      feat_valid_o <= 1'b0;
      feat_last_o  <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (accept) begin
          x_q     <= DW'($signed(sample_i)) <<< XSH;
          pos_q   <= pos_in;
          cnt_q   <= (pos_in == PW'(WIN-1)) ? '0 : pos_in + PW'(1);
          last_q  <= (pos_in == PW'(WIN-1));
          acc_q   <= z_top;
          step_q  <= '0;
          state_q <= ST_CALC;
        end
      end else begin
        step_q <= step_q + SW'(1);
        if (step_q == '0)                   s_q   <= prod;
        else if (int'(step_q) < TERMS)      acc_q <= prod + z_c;
        else if (int'(step_q) == TERMS)     acc_q <= prod;
        else if (int'(step_q) == TERMS + 1) sum_q <= AW'(f_c) + AW'(prod);
        else if (int'(step_q) == TERMS + 2) sum_q <= sum_q + AW'(prod);
        else begin
          feat_o       <= fin_sat;
          feat_valid_o <= 1'b1;
          feat_last_o  <= last_q;
          state_q      <= ST_IDLE;
        end
      end
    end
  end

  // R4
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
  // R4
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_valid_o |=> !feat_valid_o);
  // R4
  calc_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CALC) |-> (int'(step_q) < NSTEP));
  // R5
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_last_o |-> feat_valid_o);
  // R6
  restart_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && first_i) |=> (cnt_q == PW'(1)));
endmodule

// File: tb/sim_fte_feature_engine.sv
module sim_fte_feature_engine;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0, first_i = 1'b0;
  logic [7:0] sample_i = '0;
  logic       ready_o, feat_valid_o, feat_last_o;
  logic [15:0] feat_o;

  int n_chk = 0, n_fail = 0, pos_m = 0;

  always #10 clk = ~clk;

  fte_feature_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .first_i(first_i),
    .sample_i(sample_i), .ready_o(ready_o), .feat_o(feat_o),
    .feat_valid_o(feat_valid_o), .feat_last_o(feat_last_o)
  );

  // {first, sample}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 8'h00}, {1'b0, 8'h10}, {1'b0, 8'h7f}, {1'b0, 8'h80},
    {1'b0, 8'hf0}, {1'b1, 8'h20}, {1'b0, 8'hc0}, {1'b0, 8'h05}
  };

  function automatic int model(input int pos, input int xs);
    real c, d, f, g, np, v;
    if (pos < 25) begin c = 0.8811360429; d = 0.8485988992; f = 0.3445652340; g = 0.3857726869; end
    else begin c = -0.6759430538; d = 0.9296483879; f = -0.2087852761; g = 0.5826642888; end
    np = real'((pos % 25) + 1) / 25.0;
    v  = (c*np + d*(real'(xs)/16.0) + f + g*$sin(np/1.6)) * 4096.0;
    if (v > 32767.0) return 32767;
    if (v < -32768.0) return -32768;
    return int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] s, input logic f);
    valid_i = 1'b1; sample_i = s; first_i = f;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    valid_i = 1'b0; first_i = 1'b0;
  endtask

  task automatic get(output int fv, output bit lst, output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!feat_valid_o && lat < 200);
    fv  = int'($signed(feat_o));
    lst = feat_last_o;
    if (!feat_valid_o) check(1'b0, "R4 no feature", 0, 1);
  endtask

  task automatic score(input int fv, input bit lst, input logic [7:0] s, input string req);
    int e = model(pos_m, int'($signed(s)));
    int diff = fv - e;
    check(diff <= 8 && diff >= -8, (pos_m < 25) ? req : "R3", fv, e);
    check(lst == (pos_m == 49), "R5 last", int'(lst), int'(pos_m == 49));
    pos_m = (pos_m == 49) ? 0 : pos_m + 1;
  endtask

  task automatic run(input logic [7:0] s, input logic f, input string req);
    int fv, lat; bit lst;
    if (f) pos_m = 0;
    send(s, f);
    get(fv, lst, lat);
    check(lat == 14, "R4 latency", lat, 14);
    score(fv, lst, s, req);
  endtask

  initial begin
    int fv, lat; bit lst;
    repeat (3) @(negedge clk);
    check(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
    check(feat_valid_o == 1'b0, "R1 valid", int'(feat_valid_o), 0);
    check(feat_last_o == 1'b0, "R1 last", int'(feat_last_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // table walk; entry 0 checks position 0 after reset (R1), entry 5 restarts (R6)
    for (int i = 0; i < 8; i++) run(VEC[i][7:0], VEC[i][8], (i == 0) ? "R1" : "R2");

    // full window: R2 then R3, last flag R5
    run(8'h33, 1'b1, "R6");
    for (int i = 1; i < 50; i++) run(8'((i*53 + 7) % 256), 1'b0, "R2");
    // wrap to position 0 after the last
    run(8'h40, 1'b0, "R5 wrap");

    // saturation at end of segment 1 (R7)
    pos_m = 0;
    for (int i = 0; i < 24; i++) run(8'h7f, (i == 0), "R7");
    send(8'h7f, 1'b0);
    get(fv, lst, lat);
    check(fv == 32767, "R7 clamp", fv, 32767);
    pos_m++;

    // busy-time offers ignored (R8)
    send(8'h12, 1'b0);
    valid_i = 1'b1; sample_i = 8'h80; first_i = 1'b1;
    repeat (6) @(negedge clk);
    valid_i = 1'b0; first_i = 1'b0;
    get(fv, lst, lat);
    score(fv, lst, 8'h12, "R8");
    run(8'hd8, 1'b0, "R8");

    // reset mid-window returns position to 0 (R1)
    rst_ni = 1'b0;
    @(negedge clk);
    check(ready_o == 1'b1, "R1 ready after reset", int'(ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    pos_m = 0;
    run(8'h08, 1'b0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule